// File: doc/BRIEF.md
# Masked vector lane OR unit

This execution unit combines two packed source vectors of 32-bit lanes with a bitwise OR and produces a new 512-bit destination value one clock later. A per-lane write mask decides which lanes take the OR result. Lanes that are not written either keep the old destination contents (merge) or are cleared (zero). The second source can be replaced by a single 32-bit value copied into every active lane. Lane contents are raw bit patterns, so NaN, infinity and denormal encodings pass through untouched, and the unit produces no floating-point flags.

The caller supplies the current destination value on `dst_old`, so the unit holds no register-file state of its own. A 2-bit length code picks 128, 256 or 512 active bits. Outside legacy mode, every bit above the active length is cleared. Legacy mode fixes the operation at 128 bits, unmasked and without broadcast, and passes `dst_old[511:128]` through unchanged. Length code 3 is reserved: it flags an error and returns `dst_old` as it is.

Top module: `vlor_unit`

## Requirements
- R1: With masking disabled, in non-legacy mode, every active lane j receives `src_a` lane j OR `src_b` lane j, bit for bit, with no special case for any floating-point encoding.
- R2: With `mask_en`=1, an active lane whose `wr_mask` bit j is 1 receives the OR result.
- R3: With `mask_en`=1 and `zero_sel`=0, an active lane whose mask bit is 0 keeps its `dst_old` value.
- R4: With `mask_en`=1 and `zero_sel`=1, an active lane whose mask bit is 0 becomes all zeros.
- R5: When both `bcast` and `b_is_mem` are 1 in non-legacy mode, every active lane uses `src_b[31:0]` as its second operand. When `bcast` is 1 and `b_is_mem` is 0, each lane uses its own slice of `src_b`.
- R6: In non-legacy mode, `vlen_code` 0, 1 and 2 select 4, 8 and 16 active lanes (128, 256 and 512 bits). All result bits from the active length up to bit 511 are zero.
- R7: With `legacy`=1, bits 127:0 are `src_a|src_b`, bits 511:128 equal `dst_old[511:128]`, and `wr_mask`, `mask_en`, `zero_sel`, `bcast` and `vlen_code` have no effect. `vlen_err` is 0.
- R8: With `legacy`=0 and `vlen_code`=3, `vlen_err` is 1 and the result equals `dst_old`. `vlen_err` is 0 for every other accepted input.
- R9: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. When `in_valid`=0, `dst_new` and `vlen_err` hold their values.
- R10: While reset is asserted, `out_valid`, `vlen_err` and `dst_new` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the inputs this cycle |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Current destination value |
| wr_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Apply the write mask |
| zero_sel | input | 1 | 1: clear unwritten lanes; 0: keep them |
| bcast | input | 1 | Broadcast request for the second source |
| b_is_mem | input | 1 | Second source comes from memory |
| vlen_code | input | 2 | Active length: 0=128, 1=256, 2=512, 3=reserved |
| legacy | input | 1 | Fixed 128-bit mode that preserves the upper bits |
| out_valid | output | 1 | Result valid |
| dst_new | output | 512 | New destination value |
| vlen_err | output | 1 | Reserved length code was seen |

## Verification
The bench targets the places where masking, broadcast and length handling interact. A unit that applied broadcast without the memory qualifier would copy lane 0 into lanes that should keep their own slice. A unit that cleared the upper bits in legacy mode, or let the mask leak into it, would destroy `dst_old[511:128]` or drop lanes. Reserved length codes must return `dst_old` rather than a partial OR. Swapping merge and zero behaviour would show up as zeros where old data belongs, or the reverse. NaN and infinity patterns check that no lane is treated as a number, and idle cycles check that the result register only loads on accepted inputs.

// File: rtl/vlor_pkg.sv
package vlor_pkg;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_RSVD = 2'd3
  } vlen_e;

  typedef struct packed {
    logic legacy;
    logic bcast_on;
    logic mask_on;
    logic zero_on;
    logic rsvd;
  } lane_ctl_t;

endpackage

// File: rtl/vlor_rst_sync.sv
module vlor_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/vlor_len_dec.sv
module vlor_len_dec #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic [1:0]       vlen_code,
  input  logic             legacy,
  output logic [LANES-1:0] active,
  output logic             rsvd
);
  import vlor_pkg::*;

  localparam int BASE_LANES = 128 / LANE_W;

  int lane_cnt;

  always_comb begin
    case (vlen_e'(vlen_code))
      VL_128:  lane_cnt = BASE_LANES;
      VL_256:  lane_cnt = 2 * BASE_LANES;
      default: lane_cnt = 4 * BASE_LANES;
    endcase
    if (legacy) begin
      lane_cnt = BASE_LANES;
    end
    rsvd = !legacy && (vlen_e'(vlen_code) == VL_RSVD);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign active[j] = (j < lane_cnt);
  end
endmodule

// File: rtl/vlor_lane.sv
module vlor_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b_own,
  input  logic [LANE_W-1:0]   b_bc,
  input  logic [LANE_W-1:0]   old,
  input  logic                active,
  input  logic                wr_bit,
  input  vlor_pkg::lane_ctl_t ctl,
  output logic [LANE_W-1:0]   res
);
  logic [LANE_W-1:0] b_sel;
  logic              written;

  always_comb begin
    b_sel   = ctl.bcast_on ? b_bc : b_own;
    written = ctl.legacy || !ctl.mask_on || wr_bit;
    if (ctl.rsvd) begin
      res = old;
    end else if (!active) begin
      res = ctl.legacy ? old : '0;
    end else if (written) begin
      res = a | b_sel;
    end else begin
      res = ctl.zero_on ? '0 : old;
    end
  end
endmodule

// File: rtl/vlor_unit.sv
module vlor_unit #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] dst_old,
  input  logic [LANES-1:0]        wr_mask,
  input  logic                    mask_en,
  input  logic                    zero_sel,
  input  logic                    bcast,
  input  logic                    b_is_mem,
  input  logic [1:0]              vlen_code,
  input  logic                    legacy,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] dst_new,
  output logic                    vlen_err
);
  import vlor_pkg::*;

  localparam int DATA_W = LANE_W * LANES;

  logic              rst_core_n;
  logic [LANES-1:0]  active;
  logic              rsvd;
  lane_ctl_t         ctl;
  logic [DATA_W-1:0] res_comb;

  logic [DATA_W-1:0] dst_q, dst_d;
  logic              err_q, err_d;
  logic              vld_q, vld_d;

  vlor_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  vlor_len_dec #(.LANE_W(LANE_W), .LANES(LANES)) u_dec (
    .vlen_code (vlen_code),
    .legacy    (legacy),
    .active    (active),
    .rsvd      (rsvd)
  );

  always_comb begin
    ctl.legacy   = legacy;
    ctl.bcast_on = !legacy && bcast && b_is_mem;
    ctl.mask_on  = !legacy && mask_en;
    ctl.zero_on  = zero_sel;
    ctl.rsvd     = rsvd;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vlor_lane #(.LANE_W(LANE_W)) u_lane (
      .a      (src_a[j*LANE_W +: LANE_W]),
      .b_own  (src_b[j*LANE_W +: LANE_W]),
      .b_bc   (src_b[LANE_W-1:0]),
      .old    (dst_old[j*LANE_W +: LANE_W]),
      .active (active[j]),
      .wr_bit (wr_mask[j]),
      .ctl    (ctl),
      .res    (res_comb[j*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    vld_d = in_valid;
    dst_d = dst_q;
    err_d = err_q;
    if (in_valid) begin
      dst_d = res_comb;
      err_d = rsvd;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dst_q <= dst_d;
      err_q <= err_d;
    end
  end

  assign out_valid = vld_q;
  assign dst_new   = dst_q;
  assign vlen_err  = err_q;
endmodule

// File: rtl/vlor_checker.sv
module vlor_checker #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANE_W*LANES-1:0] src_a,
  input logic [LANE_W*LANES-1:0] src_b,
  input logic [LANE_W*LANES-1:0] dst_old,
  input logic [LANES-1:0]        wr_mask,
  input logic                    mask_en,
  input logic                    zero_sel,
  input logic                    bcast,
  input logic                    b_is_mem,
  input logic [1:0]              vlen_code,
  input logic                    legacy,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] dst_new,
  input logic                    vlen_err
);
  localparam int DATA_W = LANE_W * LANES;

  // R10
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !vlen_err && dst_new == '0));

  // R9
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_new) && $stable(vlen_err)));

  // R1
  assert_plain_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_code == 2'd2 && !mask_en && !(bcast && b_is_mem))
    |=> dst_new == $past(src_a | src_b));

  // R3
  assert_merge_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_code == 2'd2 && mask_en && !zero_sel && wr_mask == '0)
    |=> dst_new == $past(dst_old));

  // R4
  assert_zero_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_code != 2'd3 && mask_en && zero_sel && wr_mask == '0)
    |=> dst_new == '0);

  // R6
  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_code == 2'd0)
    |=> dst_new[DATA_W-1:128] == '0);

  // R7
  assert_legacy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy)
    |=> (dst_new[DATA_W-1:128] == $past(dst_old[DATA_W-1:128]) &&
         dst_new[127:0] == $past(src_a[127:0] | src_b[127:0]) && !vlen_err));

  // R8
  assert_rsvd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen_code == 2'd3)
    |=> (vlen_err && dst_new == $past(dst_old)));
endmodule

bind vlor_unit vlor_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_vlor_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .src_a     (src_a),
  .src_b     (src_b),
  .dst_old   (dst_old),
  .wr_mask   (wr_mask),
  .mask_en   (mask_en),
  .zero_sel  (zero_sel),
  .bcast     (bcast),
  .b_is_mem  (b_is_mem),
  .vlen_code (vlen_code),
  .legacy    (legacy),
  .out_valid (out_valid),
  .dst_new   (dst_new),
  .vlen_err  (vlen_err)
);

// File: tb/vlor_unit_bench.sv
`timescale 1ns/1ps
module vlor_unit_bench;
  localparam int LW = 32;
  localparam int NL = 16;
  localparam int DW = LW * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [NL-1:0] wr_mask = '0;
  logic          mask_en = 1'b0, zero_sel = 1'b0, bcast = 1'b0, b_is_mem = 1'b0;
  logic [1:0]    vlen_code = 2'd0;
  logic          legacy = 1'b0;
  logic          out_valid;
  logic [DW-1:0] dst_new;
  logic          vlen_err;

  int n_total = 0;
  int n_bad   = 0;

  always #4 clk = ~clk;

  vlor_unit u_vlor_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .wr_mask(wr_mask), .mask_en(mask_en), .zero_sel(zero_sel),
    .bcast(bcast), .b_is_mem(b_is_mem), .vlen_code(vlen_code),
    .legacy(legacy), .out_valid(out_valid), .dst_new(dst_new),
    .vlen_err(vlen_err)
  );

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int k = 0; k < NL; k++) v[k*LW +: LW] = $urandom;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_dst();
    logic [DW-1:0] r;
    int cnt;
    logic [LW-1:0] bop;
    if (!legacy && vlen_code == 2'd3) return dst_old;
    cnt = legacy ? 4 : (vlen_code == 2'd0 ? 4 : (vlen_code == 2'd1 ? 8 : 16));
    for (int k = 0; k < NL; k++) begin
      bop = (!legacy && bcast && b_is_mem) ? src_b[LW-1:0] : src_b[k*LW +: LW];
      if (k >= cnt)
        r[k*LW +: LW] = legacy ? dst_old[k*LW +: LW] : '0;
      else if (legacy || !mask_en || wr_mask[k])
        r[k*LW +: LW] = src_a[k*LW +: LW] | bop;
      else
        r[k*LW +: LW] = zero_sel ? '0 : dst_old[k*LW +: LW];
    end
    return r;
  endfunction

  function automatic string tag_of();
    if (legacy) return "R7";
    if (vlen_code == 2'd3) return "R8";
    if (bcast && b_is_mem) return "R5";
    if (vlen_code != 2'd2) return "R6";
    if (mask_en) return zero_sel ? "R4" : "R3";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(input string tag);
    logic [DW-1:0] e;
    logic e_err;
    e = exp_dst();
    e_err = !legacy && vlen_code == 2'd3;
    in_valid = 1'b1;
    @(negedge clk);
    chk(tag, dst_new, e);
    chk({tag, " err"}, {{(DW-1){1'b0}}, vlen_err}, {{(DW-1){1'b0}}, e_err});
    chk("R9 valid", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
  endtask

  task automatic set_mode(input logic le, input logic [1:0] vc, input logic me,
                          input logic zs, input logic bc, input logic bm,
                          input logic [NL-1:0] m);
    legacy = le; vlen_code = vc; mask_en = me; zero_sel = zs;
    bcast = bc; b_is_mem = bm; wr_mask = m;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 dst", dst_new, '0);
    chk("R10 vld", {{(DW-1){1'b0}}, out_valid}, '0);
    chk("R10 err", {{(DW-1){1'b0}}, vlen_err}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: NaN/infinity bit patterns, no masking
    src_a = {NL{32'h7FC0_0001}}; src_b = {NL{32'hFF80_0000}}; dst_old = rnd_vec();
    set_mode(0, 2'd2, 0, 0, 0, 0, '0);
    run_op("R1");
    // R2/R3: merge with alternating mask
    src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
    set_mode(0, 2'd2, 1, 0, 0, 0, 16'hA5C3);
    run_op("R2 R3 merge");
    // R4: zeroing
    set_mode(0, 2'd2, 1, 1, 0, 0, 16'h3C5A);
    run_op("R4 zero");
    // R5: broadcast with and without the memory qualifier
    set_mode(0, 2'd2, 0, 0, 1, 1, '0);
    run_op("R5 bcast mem");
    set_mode(0, 2'd2, 0, 0, 1, 0, '0);
    run_op("R5 bcast reg");
    // R6: lengths 128 and 256
    set_mode(0, 2'd0, 0, 0, 0, 0, '0);
    run_op("R6 len128");
    set_mode(0, 2'd1, 1, 0, 0, 0, 16'hFFFF);
    run_op("R6 len256");
    // R7: legacy ignores mask, zero, broadcast and length code
    set_mode(1, 2'd3, 1, 1, 1, 1, '0);
    run_op("R7 legacy");
    // R8: reserved code
    set_mode(0, 2'd3, 0, 0, 0, 0, '0);
    run_op("R8 rsvd");
    // R9: idle cycles hold the result
    held = dst_new;
    in_valid = 1'b0;
    src_a = rnd_vec(); dst_old = rnd_vec();
    set_mode(0, 2'd2, 0, 0, 0, 0, '0);
    @(negedge clk);
    chk("R9 idle vld", {{(DW-1){1'b0}}, out_valid}, '0);
    chk("R9 idle hold", dst_new, held);
    chk("R9 idle err", {{(DW-1){1'b0}}, vlen_err}, {{(DW-1){1'b0}}, 1'b1});

    // random mix
    for (int n = 0; n < 600; n++) begin
      src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
      set_mode(($urandom % 5) == 0, 2'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 16'($urandom));
      if ((n % 7) == 3) begin
        in_valid = 1'b0;
        held = dst_new;
        @(negedge clk);
        chk("R9 gap", dst_new, held);
      end else begin
        run_op(tag_of());
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule